// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block keeps the hardware side of a circular descriptor queue that software shares with a data-movement engine. Software fills slots in the ring and then tells the block how many slots it filled by writing a batch count. Software frees handled slots the same way, by writing a second batch count. The block tracks four values: the ring length, the producer write index, the index of the oldest completed descriptor, and the number of completed descriptors that software has not yet freed.

A one-cycle completion strobe stands in for the engine finishing a descriptor. The strobe takes effect only while the engine is running and work is outstanding. Each completion moves one descriptor from outstanding to completed, in ring order. A programmable threshold on the completed count controls a message-style interrupt pulse. Software sets the threshold to the ring length while it handles completions, which masks new interrupts. It then writes zero to unmask them again.

All registers are 32 bits wide. They sit behind a simple write strobe and read strobe with a 12-bit byte address. Read data is registered.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset the ring length reads 4096, the descriptor format code reads 7, the engine is halted (halt register reads 1), and every index, count, threshold and error flag is 0. The interrupt output is low.
- R2: Writing the length register (0x000, bits [14:0]) sets the ring length and returns the write index, completed index, outstanding count, completed count and error flag to zero. The length register reads back the effective length. A written value of 0 acts as length 1.
- R3: Writing 1 to the format register (0x010) selects 32-byte descriptors, with a length limit of 16384. Writing 7 selects 128-byte descriptors, with a limit of 4096. Any other value is ignored. The effective length is the programmed length clamped to the limit of the current format. A valid format write also clears the indices and counts.
- R4: Writing N to the post register (0x01C) advances the write index by N modulo the effective length. The write index reads in bits [31:16] of the write-index register (0x00C).
- R5: A post count larger than the free space (length minus outstanding minus completed) is clamped to the free space and sets the error flag, status bit 31. A post or release that needs no clamping clears the error flag.
- R6: Writing 0 to the halt register (0x014) starts the engine; writing any other value halts it. A completion strobe raises the completed count only when the engine is running and at least one posted descriptor is outstanding.
- R7: Writing N to the release register (0x018) lowers the completed count by N and advances the completed index by N modulo the effective length. The status register (0x004) holds the completed count in bits [14:0] and the completed index in bits [29:16].
- R8: A release count larger than the completed count is clamped to the completed count and sets status bit 31.
- R9: The interrupt output pulses high for exactly one cycle each time the completed count goes from not above to above the threshold. It stays low while the count remains above the threshold.
- R10: The threshold register (0x008, bits [14:0]) masks interrupts while it is at or above the completed count. Lowering the threshold below a nonzero completed count counts as a crossing and produces one pulse.
- R11: Read data appears on the cycle after the read strobe. Reading an address that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| done_tick_i | input | 1 | Engine completed one descriptor |
| irq_o | output | 1 | One-cycle interrupt message pulse |

## Verification
The assertions assume one register access per cycle at most. They also assume that software changes the length or format only while the ring is idle, which is why those writes clear all state. Under these assumptions the index-range and occupancy properties follow from the post and release clamps.

The stimulus follows the same rules. It issues every access as a separate strobe cycle. It programs a length of 8 before posting any work, so that wrap-around happens after only a few batches. It deliberately overshoots the free space and the completed count, which exercises the clamps without breaking the occupancy bound.

// File: rtl/ring_pkg.sv
// Package: register offsets and the write-strobe bundle shared by the
// register decoder and the pointer core.
package ring_pkg;

    localparam int OFF_LEN  = 'h000;
    localparam int OFF_STAT = 'h004;
    localparam int OFF_THR  = 'h008;
    localparam int OFF_WPTR = 'h00C;
    localparam int OFF_FMT  = 'h010;
    localparam int OFF_HALT = 'h014;
    localparam int OFF_REL  = 'h018;
    localparam int OFF_POST = 'h01C;

    localparam logic [31:0] FMT_SMALL_CODE = 32'd1;
    localparam logic [31:0] FMT_LARGE_CODE = 32'd7;

    typedef struct packed {
        logic len_we;
        logic fmt_we;
        logic thr_we;
        logic halt_we;
        logic rel_we;
        logic post_we;
    } wr_strobe_t;

endpackage

// File: rtl/ring_regif.sv
// Register decoder: turns the write strobe and address into per-register
// write pulses and returns registered read data one cycle after a read
// strobe. Assumes at most one access per cycle.
module ring_regif #(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 14,
    parameter int CNT_W  = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [ADDR_W-1:0]      reg_addr,
    output ring_pkg::wr_strobe_t   we,
    input  logic [CNT_W-1:0]       len_eff,
    input  logic                   fmt_small,
    input  logic                   running,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [IDX_W-1:0]       rd_idx,
    input  logic [CNT_W-1:0]       done_cnt,
    input  logic                   err_flag,
    input  logic [CNT_W-1:0]       thr_val,
    output logic [31:0]            rdata
);
    import ring_pkg::*;

    logic        hit;
    logic [31:0] rmux;

    // Decode writes into one pulse per register.
    always_comb begin
        we.len_we  = reg_wr && (reg_addr == ADDR_W'(OFF_LEN));
        we.fmt_we  = reg_wr && (reg_addr == ADDR_W'(OFF_FMT));
        we.thr_we  = reg_wr && (reg_addr == ADDR_W'(OFF_THR));
        we.halt_we = reg_wr && (reg_addr == ADDR_W'(OFF_HALT));
        we.rel_we  = reg_wr && (reg_addr == ADDR_W'(OFF_REL));
        we.post_we = reg_wr && (reg_addr == ADDR_W'(OFF_POST));
    end

    // Select the read value for the addressed register.
    always_comb begin
        rmux = '0;
        hit  = 1'b1;
        case (reg_addr)
            ADDR_W'(OFF_LEN):  rmux = 32'(len_eff);
            ADDR_W'(OFF_STAT): begin
                rmux[31]           = err_flag;
                rmux[16 +: IDX_W]  = rd_idx;
                rmux[0 +: CNT_W]   = done_cnt;
            end
            ADDR_W'(OFF_THR):  rmux = 32'(thr_val);
            ADDR_W'(OFF_WPTR): rmux[16 +: IDX_W] = wr_idx;
            ADDR_W'(OFF_FMT):  rmux = fmt_small ? FMT_SMALL_CODE : FMT_LARGE_CODE;
            ADDR_W'(OFF_HALT): rmux = {31'd0, !running};
            ADDR_W'(OFF_REL), ADDR_W'(OFF_POST): rmux = '0;
            default:           hit  = 1'b0;
        endcase
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (reg_rd) rdata <= rmux;
    end

    // R11: an unmapped read returns zero on the next cycle.
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !hit) |=> (rdata == 32'd0));

endmodule

// File: rtl/ring_ptr_core.sv
// Pointer core: holds ring length, descriptor format, run state, write and
// completed indices, outstanding and completed counts and the clamp error
// flag. Assumes length/format are changed only while the ring is idle; such
// writes clear all indices and counts.
module ring_ptr_core #(
    parameter int SMALL_LOG = 14,
    parameter int LARGE_LOG = 12,
    localparam int IDX_W = SMALL_LOG,
    localparam int CNT_W = SMALL_LOG + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ring_pkg::wr_strobe_t we,
    input  logic [31:0]          wdata,
    input  logic                 done_tick,
    output logic [CNT_W-1:0]     len_eff,
    output logic                 fmt_small,
    output logic                 running,
    output logic [IDX_W-1:0]     wr_idx,
    output logic [IDX_W-1:0]     rd_idx,
    output logic [CNT_W-1:0]     done_cnt,
    output logic                 err_flag
);
    import ring_pkg::*;

    localparam logic [CNT_W-1:0] LIM_SMALL = CNT_W'(1) << SMALL_LOG;
    localparam logic [CNT_W-1:0] LIM_LARGE = CNT_W'(1) << LARGE_LOG;

    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] outst_q;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] req_n, free_n, post_n, rel_n;
    logic [CNT_W:0]   wr_sum, rd_sum, wr_wrap, rd_wrap;
    logic             step, fmt_ok, cfg_clear;

    // Effective length: programmed length clamped to the format limit, floor 1.
    always_comb begin
        lim = fmt_small ? LIM_SMALL : LIM_LARGE;
        if (len_q == '0)     len_eff = CNT_W'(1);
        else if (len_q > lim) len_eff = lim;
        else                 len_eff = len_q;
    end

    // Batch clamps, completion qualifier and modulo index arithmetic.
    always_comb begin
        req_n   = wdata[CNT_W-1:0];
        free_n  = len_eff - outst_q - done_cnt;
        post_n  = (req_n > free_n)   ? free_n   : req_n;
        rel_n   = (req_n > done_cnt) ? done_cnt : req_n;
        step    = done_tick && running && (outst_q != '0);
        fmt_ok  = we.fmt_we && ((wdata == FMT_SMALL_CODE) || (wdata == FMT_LARGE_CODE));
        cfg_clear = we.len_we || fmt_ok;
        wr_sum  = {2'b00, wr_idx} + {1'b0, post_n};
        rd_sum  = {2'b00, rd_idx} + {1'b0, rel_n};
        wr_wrap = (wr_sum >= {1'b0, len_eff}) ? wr_sum - {1'b0, len_eff} : wr_sum;
        rd_wrap = (rd_sum >= {1'b0, len_eff}) ? rd_sum - {1'b0, len_eff} : rd_sum;
    end

    // Run state follows the halt register: zero runs, anything else halts.
    always_ff @(posedge clk) begin
        if (!rst_n)          running <= 1'b0;
        else if (we.halt_we) running <= (wdata == 32'd0);
    end

    // Configuration registers and ring state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q     <= LIM_LARGE;
            fmt_small <= 1'b0;
            wr_idx    <= '0;
            rd_idx    <= '0;
            outst_q   <= '0;
            done_cnt  <= '0;
            err_flag  <= 1'b0;
        end else if (cfg_clear) begin
            if (we.len_we) len_q     <= wdata[CNT_W-1:0];
            if (fmt_ok)    fmt_small <= (wdata == FMT_SMALL_CODE);
            wr_idx   <= '0;
            rd_idx   <= '0;
            outst_q  <= '0;
            done_cnt <= '0;
            err_flag <= 1'b0;
        end else begin
            outst_q  <= outst_q + (we.post_we ? post_n : '0) - CNT_W'(step);
            done_cnt <= done_cnt - (we.rel_we ? rel_n : '0) + CNT_W'(step);
            if (we.post_we) begin
                wr_idx   <= wr_wrap[IDX_W-1:0];
                err_flag <= (req_n > free_n);
            end
            if (we.rel_we) begin
                rd_idx   <= rd_wrap[IDX_W-1:0];
                err_flag <= (req_n > done_cnt);
            end
        end
    end

    // R4: the write index always lies inside the ring.
    p_wr_in_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, wr_idx} < len_eff);

    // R7: the completed index always lies inside the ring.
    p_rd_in_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, rd_idx} < len_eff);

    // R5: outstanding plus completed never exceeds the ring length.
    p_occupancy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, outst_q} + {1'b0, done_cnt}) <= {1'b0, len_eff});

    // R6: while halted the completed count never rises.
    p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !we.halt_we) |=> (done_cnt <= $past(done_cnt)));

endmodule

// File: rtl/ring_irq_gen.sv
// Interrupt generator: holds the threshold and emits a one-cycle pulse each
// time the completed count moves from not above to above the threshold.
module ring_irq_gen #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_we,
    input  logic [CNT_W-1:0] thr_wdata,
    input  logic [CNT_W-1:0] done_cnt,
    output logic [CNT_W-1:0] thr_val,
    output logic             irq
);
    logic above_c, above_q;

    // Compare the completed count against the threshold.
    always_comb above_c = (done_cnt > thr_val);

    // Threshold register.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_val <= '0;
        else if (thr_we) thr_val <= thr_wdata;
    end

    // Edge detect on the above-threshold condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            above_q <= 1'b0;
            irq     <= 1'b0;
        end else begin
            above_q <= above_c;
            irq     <= above_c && !above_q;
        end
    end

    // R9: a pulse lasts exactly one cycle.
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10: a pulse follows a cycle where the count exceeded the threshold.
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(done_cnt > thr_val));

endmodule

// File: rtl/ring_ptr_mgr.sv
// Top level: descriptor ring pointer manager. Connects the register decoder,
// the pointer core and the interrupt generator.
module ring_ptr_mgr #(
    parameter int ADDR_W    = 12,
    parameter int SMALL_LOG = 14,
    parameter int LARGE_LOG = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              done_tick_i,
    output logic              irq_o
);
    localparam int IDX_W = SMALL_LOG;
    localparam int CNT_W = SMALL_LOG + 1;

    ring_pkg::wr_strobe_t we;
    logic [CNT_W-1:0] len_eff, done_cnt, thr_val;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             fmt_small, running, err_flag;

    ring_regif #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr_i), .reg_rd(reg_rd_i), .reg_addr(reg_addr_i),
        .we(we),
        .len_eff(len_eff), .fmt_small(fmt_small), .running(running),
        .wr_idx(wr_idx), .rd_idx(rd_idx), .done_cnt(done_cnt),
        .err_flag(err_flag), .thr_val(thr_val),
        .rdata(reg_rdata_o)
    );

    ring_ptr_core #(.SMALL_LOG(SMALL_LOG), .LARGE_LOG(LARGE_LOG)) u_core (
        .clk(clk), .rst_n(rst_n),
        .we(we), .wdata(reg_wdata_i), .done_tick(done_tick_i),
        .len_eff(len_eff), .fmt_small(fmt_small), .running(running),
        .wr_idx(wr_idx), .rd_idx(rd_idx), .done_cnt(done_cnt),
        .err_flag(err_flag)
    );

    ring_irq_gen #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .thr_we(we.thr_we), .thr_wdata(reg_wdata_i[CNT_W-1:0]),
        .done_cnt(done_cnt), .thr_val(thr_val), .irq(irq_o)
    );

endmodule

// File: tb/ring_ptr_mgr_tb_top.sv
// Scoreboard bench: read tasks push expected values, a monitor pops and
// compares them when registered read data appears.
module ring_ptr_mgr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        done_tick = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    logic rd_seen = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    ring_ptr_mgr dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .done_tick_i(done_tick), .irq_o(irq)
    );

    // Track read strobes and count interrupt pulses.
    always @(posedge clk) begin
        rd_seen <= reg_rd;
        if (rst_n && irq) irq_cnt <= irq_cnt + 1;
    end

    // Monitor: compare registered read data with the scoreboard head.
    always @(negedge clk) begin
        if (rd_seen && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (reg_rdata !== it.exp) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, reg_rdata, it.exp);
            end
        end
    end

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); done_tick = 1'b1;
            @(negedge clk); done_tick = 1'b0;
        end
    endtask

    task automatic irq_check(input int e, input string tag);
        repeat (3) @(negedge clk);
        n_cmp++;
        if (irq_cnt != e) begin
            n_bad++;
            $display("FAIL %s irq pulses actual=%0d expected=%0d", tag, irq_cnt, e);
        end
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(12'h000, 32'd4096, "R1 length");
        reg_read(12'h004, 32'h0,    "R1 status");
        reg_read(12'h00C, 32'h0,    "R1 write index");
        reg_read(12'h010, 32'd7,    "R1 format");
        reg_read(12'h008, 32'h0,    "R1 threshold");
        reg_read(12'h014, 32'd1,    "R1 halted");
        irq_check(0, "R1 irq low");

        // R2 length programming
        reg_write(12'h000, 32'd8);
        reg_read(12'h000, 32'd8, "R2 length 8");

        // R3 format selection and clamp
        reg_write(12'h010, 32'd3);
        reg_read(12'h010, 32'd7, "R3 bad code ignored");
        reg_write(12'h010, 32'd1);
        reg_read(12'h010, 32'd1, "R3 small format");
        reg_write(12'h000, 32'd20000);
        reg_read(12'h000, 32'd16384, "R3 clamp small limit");
        reg_write(12'h010, 32'd7);
        reg_read(12'h000, 32'd4096, "R3 clamp large limit");
        reg_write(12'h000, 32'd0);
        reg_read(12'h000, 32'd1, "R2 zero acts as one");
        reg_write(12'h000, 32'd8);

        // R4 posting batches
        reg_write(12'h01C, 32'd5);
        reg_read(12'h00C, 32'h0005_0000, "R4 post 5");
        reg_write(12'h01C, 32'd2);
        reg_read(12'h00C, 32'h0007_0000, "R4 post 2");

        // R6 completions ignored while halted
        ticks(3);
        reg_read(12'h004, 32'h0, "R6 halted no completion");
        irq_check(0, "R6 no irq while halted");

        // R9 run, first crossing pulses once
        reg_write(12'h014, 32'd0);
        reg_read(12'h014, 32'd0, "R6 running");
        ticks(1);
        irq_check(1, "R9 first crossing");
        ticks(2);
        irq_check(1, "R9 one pulse per crossing");
        reg_read(12'h004, 32'h0000_0003, "R6 three completed");

        // R7 release
        reg_write(12'h018, 32'd2);
        reg_read(12'h004, 32'h0002_0001, "R7 release 2");

        // R10 threshold masking
        reg_write(12'h008, 32'd8);
        ticks(4);
        irq_check(1, "R10 masked");
        reg_read(12'h004, 32'h0002_0005, "R10 count while masked");
        reg_write(12'h008, 32'd0);
        irq_check(2, "R10 unmask pulses");

        // R6 no completion with nothing outstanding
        ticks(1);
        reg_read(12'h004, 32'h0002_0005, "R6 nothing outstanding");

        // R8 over-release clamps
        reg_write(12'h018, 32'd9);
        reg_read(12'h004, 32'h8007_0000, "R8 release clamp");

        // R4 wrap and R5 error clear
        reg_write(12'h01C, 32'd4);
        reg_read(12'h00C, 32'h0003_0000, "R4 wrap");
        reg_read(12'h004, 32'h0007_0000, "R5 error cleared");

        // R5 over-post clamps
        reg_write(12'h01C, 32'd10);
        reg_read(12'h00C, 32'h0007_0000, "R5 post clamp index");
        reg_read(12'h004, 32'h8007_0000, "R5 post clamp error");

        // R7 wrap of completed index
        ticks(8);
        irq_check(3, "R9 new crossing");
        reg_read(12'h004, 32'h8007_0008, "R7 full ring completed");
        reg_write(12'h018, 32'd8);
        reg_read(12'h004, 32'h0007_0000, "R7 completed index wrap");

        // R11 unmapped read
        reg_read(12'h040, 32'h0, "R11 unmapped");

        // R6 halt again
        reg_write(12'h014, 32'd1);
        reg_write(12'h01C, 32'd1);
        ticks(1);
        reg_read(12'h004, 32'h0007_0000, "R6 halted again");

        finish_run();
    end

endmodule